// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Per-Pin Interrupts

This block controls ninety general-purpose pads, split into three banks of thirty, from a plain 32-bit register bus. For each pad, software sets the direction, the output value and whether the pad belongs to the GPIO logic or to an alternate on-chip peripheral. Software can also read the pad's current level at any time, whatever its direction.

Every pad also has an interrupt path. Software chooses level or edge detection and which polarity to detect, and can enable or disable the pad's interrupt. A sticky status bit records each detection. Each bank combines its pads into a single interrupt line for the parent interrupt controller. Only pads that are inputs can raise that line.

Software can catch both edges of a pad by reading its level and then setting the polarity to the opposite value. Pad inputs pass through a two-flop synchronizer before they are used for readback or detection.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Register addresses use bits 7:4 to select a group and bits 3:2 to select a bank, with banks 0..2 at a stride of 4 bytes. The groups are: direction 0x0, polarity 0x2, trigger type 0x3, interrupt enable 0x4, status 0x5, GPIO-mode 0x6, data-in 0x7 (read-only) and data-out 0x8. Bank index 3 and every other group value read as zero, and writes to them are ignored.
- R2: Bit n (0..29) of a bank register belongs to pin n of that bank. Bits 31:30 read as zero and are ignored on write.
- R3: After reset, direction is all ones (every pin an input). Polarity, trigger type, interrupt enable, status, GPIO-mode and data-out are all zero.
- R4: A read strobe (`bus_sel`=1, `bus_we`=0) places the addressed register on `bus_rdata` in the following cycle. `bus_rdata` does not change when there is no read strobe.
- R5: When a pin's GPIO-mode bit is 1, `pad_out` is its data-out bit and `pad_oe` is the inverse of its direction bit (direction 1 = input). When the GPIO-mode bit is 0, `pad_out` and `pad_oe` copy `alt_out` and `alt_oe`.
- R6: Data-in returns the pad level after two synchronizer flops, for input pins and output pins alike.
- R7: With trigger type 1 (edge), a status bit is set on a rising edge of the synchronized input when polarity is 1, and on a falling edge when polarity is 0.
- R8: With trigger type 0 (level), a status bit is set in every cycle in which the synchronized input equals the polarity bit, so clearing it while the level persists has no lasting effect.
- R9: A status bit is never set while the pin's interrupt enable bit is 0.
- R10: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. If a detection happens in the same cycle as a clear, the bit stays set.
- R11: `bank_irq[n]` is 1 exactly when some pin of bank n has its direction, status and enable bits all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pad_in | input | 90 | Pad levels, bank n at bits 30n+29..30n |
| alt_out | input | 90 | Alternate-function output value |
| alt_oe | input | 90 | Alternate-function output enable |
| pad_out | output | 90 | Pad output value |
| pad_oe | output | 90 | Pad output enable |
| bank_irq | output | 3 | One interrupt line per bank |

## Verification
Some properties are checked on every cycle. A status bit never rises while its pin's enable bit is 0. A set status bit survives unless a zero was written to it. A status bit in edge mode only rises after the synchronized input has changed. The read data holds its value between read strobes.

Other behaviour only shows up in the bench's scenarios, which compare against a behavioural model every clock. This covers the three-cycle delay from pad to status, and a level-mode bit setting itself again right after a clear. It also covers an output pin that holds status but still cannot raise its bank's interrupt, and the alternate-function pass-through.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPIN  = 30;
  localparam int NBANK = 3;
  localparam int DW    = 32;
  localparam int AW    = 8;

  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h2,
    GRP_TYP  = 4'h3,
    GRP_IEN  = 4'h4,
    GRP_STS  = 4'h5,
    GRP_MODE = 4'h6,
    GRP_DIN  = 4'h7,
    GRP_DOUT = 4'h8
  } grp_e;

  typedef logic [NPIN-1:0] pinvec_t;

  typedef struct packed {
    pinvec_t dir;
    pinvec_t pol;
    pinvec_t typ;
    pinvec_t ien;
    pinvec_t sts;
    pinvec_t mode;
    pinvec_t din;
    pinvec_t dout;
  } bank_view_t;

  // detection per pin: level match, or level match reached by a change
  function automatic pinvec_t hit_vec(pinvec_t cur, pinvec_t prev,
                                      pinvec_t typ, pinvec_t pol);
    pinvec_t lvl;
    pinvec_t edg;
    lvl = ~(cur ^ pol);
    edg = (cur ^ prev) & lvl;
    return (typ & edg) | (~typ & lvl);
  endfunction

  function automatic logic [DW-1:0] widen(pinvec_t v);
    return {{(DW-NPIN){1'b0}}, v};
  endfunction

  function automatic pinvec_t pick_group(bank_view_t v, logic [3:0] g);
    case (g)
      GRP_DIR:  return v.dir;
      GRP_POL:  return v.pol;
      GRP_TYP:  return v.typ;
      GRP_IEN:  return v.ien;
      GRP_STS:  return v.sts;
      GRP_MODE: return v.mode;
      GRP_DIN:  return v.din;
      GRP_DOUT: return v.dout;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t sync_in,
  input  pinvec_t typ,
  input  pinvec_t pol,
  input  pinvec_t ien,
  input  pinvec_t dir,
  input  logic    sts_we,
  input  pinvec_t wdata,
  output pinvec_t sts,
  output logic    irq
);
  pinvec_t prev;
  pinvec_t hit;
  pinvec_t set_evt;
  pinvec_t clr_mask;

  assign hit      = hit_vec(sync_in, prev, typ, pol);
  assign set_evt  = ien & hit;
  assign clr_mask = {NPIN{sts_we}} & ~wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      sts  <= '0;
    end else begin
      prev <= sync_in;
      sts  <= (sts & ~clr_mask) | set_evt;
    end
  end

  assign irq = |(dir & sts & ien);

  // R9
  sts_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & ~$past(ien)) == '0));

  // R10
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts) & ~$past(clr_mask)) & ~sts) == '0));

  // R7
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & $past(typ) & ~($past(sync_in) ^ $past(prev))) == '0));
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_grp,
  input  pinvec_t    wdata,
  input  pinvec_t    pad_in,
  input  pinvec_t    alt_out,
  input  pinvec_t    alt_oe,
  output pinvec_t    pad_out,
  output pinvec_t    pad_oe,
  output logic       irq,
  output bank_view_t view
);
  pinvec_t dir, pol, typ, ien, mode, dout;
  pinvec_t din_s;
  pinvec_t sts;
  logic    sts_we;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (din_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir  <= '1;
      pol  <= '0;
      typ  <= '0;
      ien  <= '0;
      mode <= '0;
      dout <= '0;
    end else if (wr_en) begin
      case (wr_grp)
        GRP_DIR:  dir  <= wdata;
        GRP_POL:  pol  <= wdata;
        GRP_TYP:  typ  <= wdata;
        GRP_IEN:  ien  <= wdata;
        GRP_MODE: mode <= wdata;
        GRP_DOUT: dout <= wdata;
        default: ;
      endcase
    end
  end

  assign sts_we = wr_en && (wr_grp == GRP_STS);

  gpio_irq_unit u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_in(din_s),
    .typ    (typ),
    .pol    (pol),
    .ien    (ien),
    .dir    (dir),
    .sts_we (sts_we),
    .wdata  (wdata),
    .sts    (sts),
    .irq    (irq)
  );

  assign pad_out = (mode & dout) | (~mode & alt_out);
  assign pad_oe  = (mode & ~dir) | (~mode & alt_oe);

  assign view = '{dir: dir, pol: pol, typ: typ, ien: ien, sts: sts,
                  mode: mode, din: din_s, dout: dout};
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NBANK*NPIN-1:0] pad_in,
  input  logic [NBANK*NPIN-1:0] alt_out,
  input  logic [NBANK*NPIN-1:0] alt_oe,
  output logic [NBANK*NPIN-1:0] pad_out,
  output logic [NBANK*NPIN-1:0] pad_oe,
  output logic [NBANK-1:0]      bank_irq
);
  localparam int BSEL_W = 2;

  logic [BSEL_W-1:0] bank_idx;
  logic [3:0]        grp;
  logic              rd_stb;
  logic              wr_stb;
  bank_view_t        views [NBANK];
  pinvec_t           rd_pick;

  assign bank_idx = bus_addr[3:2];
  assign grp      = bus_addr[7:4];
  assign rd_stb   = bus_sel && !bus_we;
  assign wr_stb   = bus_sel && bus_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_bank_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_stb && (bank_idx == BSEL_W'(b))),
      .wr_grp (grp),
      .wdata  (bus_wdata[NPIN-1:0]),
      .pad_in (pad_in[b*NPIN +: NPIN]),
      .alt_out(alt_out[b*NPIN +: NPIN]),
      .alt_oe (alt_oe[b*NPIN +: NPIN]),
      .pad_out(pad_out[b*NPIN +: NPIN]),
      .pad_oe (pad_oe[b*NPIN +: NPIN]),
      .irq    (bank_irq[b]),
      .view   (views[b])
    );
  end

  always_comb begin
    rd_pick = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_idx == BSEL_W'(b)) rd_pick = pick_group(views[b], grp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= widen(rd_pick);
  end

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int NP = 30;
  localparam int NB = 3;
  localparam int NT = NP * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NT-1:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [NT-1:0] pad_out, pad_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .bank_irq(bank_irq)
  );

  // behavioural reference model
  logic [29:0] m_dir [NB], m_pol [NB], m_typ [NB], m_ien [NB], m_sts [NB];
  logic [29:0] m_mode [NB], m_dout [NB], m_s1 [NB], m_s2 [NB], m_prv [NB];
  logic [31:0] m_rd;
  bit          m_rd_new;

  function automatic logic [31:0] m_read(int g, int b);
    logic [29:0] v;
    if (b >= NB) return 32'h0;
    case (g)
      0: v = m_dir[b];  2: v = m_pol[b];  3: v = m_typ[b];
      4: v = m_ien[b];  5: v = m_sts[b];  6: v = m_mode[b];
      7: v = m_s2[b];   8: v = m_dout[b];
      default: v = '0;
    endcase
    return {2'b00, v};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NB; k++) begin
        m_dir[k] = '1; m_pol[k] = '0; m_typ[k] = '0; m_ien[k] = '0;
        m_sts[k] = '0; m_mode[k] = '0; m_dout[k] = '0;
        m_s1[k] = '0; m_s2[k] = '0; m_prv[k] = '0;
      end
      m_rd = '0;
      m_rd_new = 0;
    end else begin
      int g, b;
      g = int'(bus_addr[7:4]);
      b = int'(bus_addr[3:2]);
      m_rd_new = bus_sel && !bus_we;
      if (m_rd_new) m_rd = m_read(g, b);
      for (int k = 0; k < NB; k++) begin
        for (int i = 0; i < NP; i++) begin
          bit match, fire;
          match = (m_s2[k][i] == m_pol[k][i]);
          if (m_typ[k][i]) fire = match && (m_s2[k][i] != m_prv[k][i]);
          else             fire = match;
          if (bus_sel && bus_we && g == 5 && b == k && !bus_wdata[i])
            m_sts[k][i] = 1'b0;
          if (fire && m_ien[k][i]) m_sts[k][i] = 1'b1;
        end
        if (bus_sel && bus_we && b == k) begin
          case (g)
            0: m_dir[k]  = bus_wdata[29:0];
            2: m_pol[k]  = bus_wdata[29:0];
            3: m_typ[k]  = bus_wdata[29:0];
            4: m_ien[k]  = bus_wdata[29:0];
            6: m_mode[k] = bus_wdata[29:0];
            8: m_dout[k] = bus_wdata[29:0];
            default: ;
          endcase
        end
        m_prv[k] = m_s2[k];
        m_s2[k]  = m_s1[k];
        m_s1[k]  = pad_in[k*NP +: NP];
      end
    end
  end

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, a quarter period after the edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      logic [NT-1:0] e_out, e_oe;
      logic [NB-1:0] e_irq;
      for (int k = 0; k < NB; k++) begin
        for (int i = 0; i < NP; i++) begin
          int p;
          p = k * NP + i;
          e_out[p] = m_mode[k][i] ? m_dout[k][i] : alt_out[p];
          e_oe[p]  = m_mode[k][i] ? !m_dir[k][i] : alt_oe[p];
        end
        e_irq[k] = |(m_dir[k] & m_sts[k] & m_ien[k]);
      end
      chk("R5 pad_out", 96'(pad_out), 96'(e_out));
      chk("R5 pad_oe", 96'(pad_oe), 96'(e_oe));
      chk("R11 bank_irq", 96'(bank_irq), 96'(e_irq));
      if (m_rd_new) chk("R4 rdata vs model", 96'(bus_rdata), 96'(m_rd));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, 96'(d), 96'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(2);
    // R3 reset values
    rd_chk("R3 dir reset", 8'h00, 32'h3FFF_FFFF);
    rd_chk("R3 ien reset", 8'h44, 32'h0);
    rd_chk("R3 sts reset", 8'h58, 32'h0);
    rd_chk("R3 mode reset", 8'h68, 32'h0);
    rd_chk("R3 dout reset", 8'h80, 32'h0);
    // R2 upper bits
    wr(8'h80, 32'hFFFF_FFFF);
    rd_chk("R2 upper bits zero", 8'h80, 32'h3FFF_FFFF);
    // R1 map and bank stride
    wr(8'h84, 32'h1234_5678);
    rd_chk("R1 bank1 dout", 8'h84, 32'h1234_5678);
    rd_chk("R1 bank0 untouched", 8'h80, 32'h3FFF_FFFF);
    rd_chk("R1 bank2 untouched", 8'h88, 32'h0);
    wr(8'h8C, 32'h0000_FFFF);
    rd_chk("R1 bank3 reads zero", 8'h8C, 32'h0);
    wr(8'h90, 32'h0000_FFFF);
    rd_chk("R1 unmapped group", 8'h90, 32'h0);
    rd_chk("R1 bank2 after bank3 write", 8'h88, 32'h0);
    // R5 pad drive
    wr(8'h60, 32'h0000_000F);
    wr(8'h00, 32'h3FFF_FFFC);
    idle(1);
    chk("R5 oe gpio pins", 96'(pad_oe[3:0]), 96'(4'b0011));
    chk("R5 out alt pin low", 96'(pad_out[4]), 96'(1'b0));
    alt_out[4] = 1; alt_oe[4] = 1;
    idle(1);
    chk("R5 out alt pin high", 96'({pad_out[4], pad_oe[4]}), 96'(2'b11));
    // R6 data-in regardless of direction
    pad_in[1] = 1; pad_in[5] = 1;
    idle(3);
    rd_chk("R6 din", 8'h70, 32'h0000_0022);
    // R7 rising edge on pin 8
    wr(8'h30, 32'h0000_0100);
    wr(8'h20, 32'h0000_0100);
    wr(8'h40, 32'h0000_0100);
    pad_in[8] = 1;
    idle(4);
    rd_chk("R7 rising sets sts", 8'h50, 32'h0000_0100);
    chk("R11 irq from input pin", 96'(bank_irq), 96'(3'b001));
    wr(8'h50, 32'h3FFF_FFFF);
    rd_chk("R10 write one keeps", 8'h50, 32'h0000_0100);
    wr(8'h50, 32'h3FFF_FEFF);
    rd_chk("R10 write zero clears", 8'h50, 32'h0);
    chk("R11 irq drops", 96'(bank_irq), 96'(3'b000));
    // R7 falling edge
    wr(8'h20, 32'h0);
    pad_in[8] = 0;
    idle(4);
    rd_chk("R7 falling sets sts", 8'h50, 32'h0000_0100);
    wr(8'h50, 32'h0);
    // R9 disabled pin does not latch
    wr(8'h40, 32'h0);
    pad_in[8] = 1;
    idle(4);
    rd_chk("R9 disabled no sts", 8'h50, 32'h0);
    // R8 level mode on pin 9
    wr(8'h20, 32'h0000_0200);
    wr(8'h40, 32'h0000_0200);
    idle(3);
    rd_chk("R8 inactive level", 8'h50, 32'h0);
    pad_in[9] = 1;
    idle(4);
    rd_chk("R8 active level sets", 8'h50, 32'h0000_0200);
    wr(8'h50, 32'h0);
    rd_chk("R8 level re-sets after clear", 8'h50, 32'h0000_0200);
    // R11 output pin holds status but no irq
    wr(8'h00, 32'h3FFF_FDFF);
    idle(1);
    chk("R11 output pin masked", 96'(bank_irq), 96'(3'b000));
    wr(8'h00, 32'h3FFF_FFFF);
    idle(1);
    chk("R11 input pin again", 96'(bank_irq), 96'(3'b001));
    pad_in[9] = 0;
    idle(3);
    wr(8'h50, 32'h0);
    rd_chk("R8 cleared after level gone", 8'h50, 32'h0);
    // mixed traffic against the model, covering all banks
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 0) begin
        logic [7:0] a;
        a = 8'($urandom_range(0, 9) << 4) | 8'($urandom_range(0, 3) << 2);
        wr(a, $urandom);
      end else if (sel == 1) begin
        logic [31:0] d;
        rd(8'($urandom_range(0, 8) << 4) | 8'($urandom_range(0, 3) << 2), d);
      end else begin
        @(negedge clk);
        pad_in[$urandom_range(0, NT-1)] ^= 1'b1;
        alt_out[$urandom_range(0, NT-1)] ^= 1'b1;
        alt_oe[$urandom_range(0, NT-1)] ^= 1'b1;
      end
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule